// File: doc/BRIEF.md
# Write-Only Two-Wire Configuration Receiver

This block is a slave on a two-wire serial bus (SCL/SDA). It accepts only block writes and turns them into the contents of four 8-bit control registers. Both bus lines are brought into the system clock domain through two-flop synchronizers. Start and stop conditions are found from the synchronized levels. Each byte is shifted in with the most significant bit first, and the receiver acknowledges a byte by pulling SDA low for the ninth clock.

A frame always has ten bytes. It opens with the slave address. The command byte and the count byte come next; they are acknowledged and their contents thrown away. Seven data bytes follow. The first three data bytes are discarded, and the last four each load one control register. Write-only registers keep their reset defaults until a matching frame overwrites them. The open-drain pad sits outside the block and is represented by a pull-low enable.

Top module: `cfg_serial_rx`

## Requirements
- R1: The address byte is acknowledged only when it equals 8'hD2. On any other address the receiver never pulls SDA low for the rest of the frame, and no register changes.
- R2: Byte positions 7, 8, 9 and 10 of a frame (counting the address as 1) load control registers 0, 1, 2 and 3. These are cfg_o[7:0], [15:8], [23:16] and [31:24].
- R3: Byte positions 2 and 3 (command and count) are acknowledged whatever their value, and they change no register.
- R4: Byte positions 4, 5 and 6 are acknowledged and discarded.
- R5: Serial bits are assembled most significant bit first.
- R6: After reset cfg_o is 32'h137F4300 and sda_pull_o is 0.
- R7: In a matching frame every byte is acknowledged. The pull-down starts after the SCL fall that ends bit 8 and is released after the next SCL fall.
- R8: A start condition in the middle of a frame restarts it, so the next byte is treated as an address.
- R9: A stop condition before byte 10 keeps the registers already written and leaves the rest unchanged.
- R10: Take the system clock edge that first samples SCL low after bit 8 as edge one. The pull-down starts on edge three, and the register of that byte takes its value on edge four.
- R11: Bytes after the tenth in a frame are not acknowledged and have no effect.
- R12: Reserved bits always read 0. The writable masks are 8'hFB, 8'h43, 8'h7F and 8'h13 for registers 0 to 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level, as resolved on the bus |
| sda_pull_o | output | 1 | Pull-low enable for the open-drain data pad |
| cfg_o | output | 32 | Four control registers, register 0 in the low byte |

## Verification
The main function is driven with these frame patterns:
- a matching frame whose data values differ from their bit-reversals, which separates MSB-first assembly from LSB-first;
- frames whose addresses sit one bit or one shift away from the match, which shows the address compare is exact;
- all-ones data, which exposes any reserved bit that is not masked;
- frames cut short by a stop, restarted by a second start, or run past ten bytes, which separate per-byte commits from whole-frame commits and show that the byte counter rewinds and saturates.

Every clock the bench compares the pull-down and all four registers against a behavioural model that schedules each expected change a fixed number of edges after the SCL fall that causes it. This pins down the latency as well as the values.

// File: rtl/cfg_rx_pkg.sv
package cfg_rx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RECV = 2'd1,
    ST_ACK  = 2'd2
  } rx_state_t;

endpackage

// File: rtl/cfg_line_sync.sv
module cfg_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);

  logic [STAGES-1:0] chain;
  logic              prev;

  // Idle bus level is high, so reset to ones to avoid a false edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '1;
      prev  <= 1'b1;
    end else begin
      chain <= {chain[STAGES-2:0], line_i};
      prev  <= chain[STAGES-1];
    end
  end

  assign level_o = chain[STAGES-1];
  assign rise_o  = chain[STAGES-1] & ~prev;
  assign fall_o  = ~chain[STAGES-1] & prev;

endmodule

// File: rtl/cfg_frame_engine.sv
module cfg_frame_engine
  import cfg_rx_pkg::*;
#(
  parameter int              BYTE_W      = 8,
  parameter int              FRAME_BYTES = 10,
  parameter int              FIRST_REG   = 6,
  parameter int              NUM_REGS    = 4,
  parameter logic [BYTE_W-1:0] SLV_ADDR  = 8'hD2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                scl_lvl,
  input  logic                scl_rise,
  input  logic                scl_fall,
  input  logic                sda_lvl,
  input  logic                sda_rise,
  input  logic                sda_fall,
  output logic                sda_pull_o,
  output logic                wr_en_o,
  output logic [NUM_REGS-1:0] wr_sel_o,
  output logic [BYTE_W-1:0]   wr_data_o
);

  localparam int IDX_W = $clog2(FRAME_BYTES);
  localparam int CNT_W = $clog2(BYTE_W + 1);

  rx_state_t           state;
  logic [CNT_W-1:0]    bit_cnt;
  logic [IDX_W-1:0]    byte_idx;
  logic [BYTE_W-1:0]   shreg;

  logic                start_c;
  logic                stop_c;
  logic                byte_full;
  logic                take;
  logic                last_byte;
  logic                is_reg;
  logic [NUM_REGS-1:0] sel_c;

  assign start_c   = scl_lvl & sda_fall;
  assign stop_c    = scl_lvl & sda_rise;
  assign byte_full = (bit_cnt == CNT_W'(BYTE_W));
  assign last_byte = (byte_idx == IDX_W'(FRAME_BYTES - 1));
  assign take      = (byte_idx == '0) ? (shreg == SLV_ADDR) : 1'b1;

  // Decode the frame position to a register target.
  always_comb begin
    for (int i = 0; i < NUM_REGS; i++) begin
      sel_c[i] = (byte_idx == IDX_W'(FIRST_REG + i));
    end
  end
  assign is_reg = |sel_c;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      bit_cnt    <= '0;
      byte_idx   <= '0;
      shreg      <= '0;
      sda_pull_o <= 1'b0;
      wr_en_o    <= 1'b0;
      wr_sel_o   <= '0;
      wr_data_o  <= '0;
    end else begin
      wr_en_o <= 1'b0;
      if (start_c) begin
        state      <= ST_RECV;
        bit_cnt    <= '0;
        byte_idx   <= '0;
        sda_pull_o <= 1'b0;
      end else if (stop_c) begin
        state      <= ST_IDLE;
        sda_pull_o <= 1'b0;
      end else begin
        case (state)
          ST_RECV: begin
            if (scl_rise && !byte_full) begin
              shreg   <= {shreg[BYTE_W-2:0], sda_lvl};
              bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall && byte_full) begin
              if (take) begin
                sda_pull_o <= 1'b1;
                state      <= ST_ACK;
                if (is_reg) begin
                  wr_en_o   <= 1'b1;
                  wr_sel_o  <= sel_c;
                  wr_data_o <= shreg;
                end
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              sda_pull_o <= 1'b0;
              bit_cnt    <= '0;
              if (last_byte) begin
                state <= ST_IDLE;
              end else begin
                byte_idx <= byte_idx + 1'b1;
                state    <= ST_RECV;
              end
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank #(
  parameter int                         BYTE_W   = 8,
  parameter int                         NUM_REGS = 4,
  parameter logic [NUM_REGS*BYTE_W-1:0] DEFAULTS = 32'h137F4300,
  parameter logic [NUM_REGS*BYTE_W-1:0] WMASKS   = 32'h137F43FB
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en_i,
  input  logic [NUM_REGS-1:0]        wr_sel_i,
  input  logic [BYTE_W-1:0]          wr_data_i,
  output logic [NUM_REGS*BYTE_W-1:0] regs_o
);

  logic [BYTE_W-1:0] store [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        store[g] <= DEFAULTS[g*BYTE_W +: BYTE_W];
      end else if (wr_en_i && wr_sel_i[g]) begin
        store[g] <= wr_data_i & WMASKS[g*BYTE_W +: BYTE_W];
      end
    end
    assign regs_o[g*BYTE_W +: BYTE_W] = store[g];
  end

endmodule

// File: rtl/cfg_serial_rx.sv
module cfg_serial_rx #(
  parameter int                         BYTE_W      = 8,
  parameter int                         NUM_REGS    = 4,
  parameter int                         FRAME_BYTES = 10,
  parameter int                         FIRST_REG   = 6,
  parameter int                         SYNC_STAGES = 2,
  parameter logic [BYTE_W-1:0]          SLV_ADDR    = 8'hD2,
  parameter logic [NUM_REGS*BYTE_W-1:0] DEFAULTS    = 32'h137F4300,
  parameter logic [NUM_REGS*BYTE_W-1:0] WMASKS      = 32'h137F43FB
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       scl_i,
  input  logic                       sda_i,
  output logic                       sda_pull_o,
  output logic [NUM_REGS*BYTE_W-1:0] cfg_o
);

  logic                scl_lvl, scl_rise, scl_fall;
  logic                sda_lvl, sda_rise, sda_fall;
  logic                wr_en;
  logic [NUM_REGS-1:0] wr_sel;
  logic [BYTE_W-1:0]   wr_data;

  cfg_line_sync #(.STAGES(SYNC_STAGES)) i_scl_sync (
    .clk(clk), .rst(rst), .line_i(scl_i),
    .level_o(scl_lvl), .rise_o(scl_rise), .fall_o(scl_fall)
  );

  cfg_line_sync #(.STAGES(SYNC_STAGES)) i_sda_sync (
    .clk(clk), .rst(rst), .line_i(sda_i),
    .level_o(sda_lvl), .rise_o(sda_rise), .fall_o(sda_fall)
  );

  cfg_frame_engine #(
    .BYTE_W(BYTE_W), .FRAME_BYTES(FRAME_BYTES), .FIRST_REG(FIRST_REG),
    .NUM_REGS(NUM_REGS), .SLV_ADDR(SLV_ADDR)
  ) i_engine (
    .clk(clk), .rst(rst),
    .scl_lvl(scl_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_lvl(sda_lvl), .sda_rise(sda_rise), .sda_fall(sda_fall),
    .sda_pull_o(sda_pull_o), .wr_en_o(wr_en), .wr_sel_o(wr_sel),
    .wr_data_o(wr_data)
  );

  cfg_reg_bank #(
    .BYTE_W(BYTE_W), .NUM_REGS(NUM_REGS), .DEFAULTS(DEFAULTS), .WMASKS(WMASKS)
  ) i_bank (
    .clk(clk), .rst(rst), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .regs_o(cfg_o)
  );

endmodule

// File: rtl/cfg_rx_checker.sv
module cfg_rx_checker #(
  parameter int                         BYTE_W   = 8,
  parameter int                         NUM_REGS = 4,
  parameter logic [NUM_REGS*BYTE_W-1:0] DEFAULTS = 32'h137F4300,
  parameter logic [NUM_REGS*BYTE_W-1:0] WMASKS   = 32'h137F43FB
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       scl_lvl,
  input logic                       sda_pull_o,
  input logic                       wr_en,
  input logic [NUM_REGS-1:0]        wr_sel,
  input logic [NUM_REGS*BYTE_W-1:0] cfg_o
);

  a_r6_reset_defaults: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (cfg_o == DEFAULTS && !sda_pull_o));

  a_r12_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    (cfg_o & ~WMASKS) == '0);

  a_r9_hold_without_write: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(cfg_o));

  a_r2_single_target: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_sel & {NUM_REGS{wr_en}}));

  a_r7_pull_while_scl_low: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_pull_o) |-> !scl_lvl);

endmodule

bind cfg_serial_rx cfg_rx_checker #(
  .BYTE_W(BYTE_W), .NUM_REGS(NUM_REGS), .DEFAULTS(DEFAULTS), .WMASKS(WMASKS)
) i_cfg_rx_checker (
  .clk(clk), .rst(rst), .scl_lvl(scl_lvl), .sda_pull_o(sda_pull_o),
  .wr_en(wr_en), .wr_sel(wr_sel), .cfg_o(cfg_o)
);

// File: tb/test_cfg_serial_rx.sv
`timescale 1ns/1ps
module test_cfg_serial_rx;

  localparam int          H      = 8;
  localparam logic [31:0] DEFV   = 32'h137F4300;
  localparam logic [31:0] WMASK  = 32'h137F43FB;
  localparam logic [7:0]  MYADDR = 8'hD2;

  logic        clk   = 1'b0;
  logic        rst   = 1'b1;
  logic        scl_m = 1'b1;
  logic        sda_m = 1'b1;
  logic        sda_line;
  logic        sda_pull;
  logic [31:0] cfg;

  always #2.5 clk = ~clk;

  assign sda_line = sda_m & ~sda_pull;

  cfg_serial_rx i_cfg_serial_rx (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line),
    .sda_pull_o(sda_pull), .cfg_o(cfg)
  );

  int pc = 0;
  always @(posedge clk) pc++;

  // Reference model state.
  int          checks = 0;
  int          errors = 0;
  bit          done   = 0;
  string       tag    = "R6";
  logic [31:0] exp_cfg  = DEFV;
  logic        exp_pull = 1'b0;
  logic [31:0] nxt_cfg  = DEFV;
  bit          m_active = 0;
  int          m_idx    = 0;
  int          due_q[$];
  int          kind_q[$];
  logic [31:0] val_q[$];

  task automatic sched(input int due, input int kind, input logic [31:0] v);
    due_q.push_back(due);
    kind_q.push_back(kind);
    val_q.push_back(v);
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      while (due_q.size() > 0 && due_q[0] <= pc) begin
        if (kind_q[0] == 0) exp_pull = val_q[0][0];
        else exp_cfg = val_q[0];
        void'(due_q.pop_front());
        void'(kind_q.pop_front());
        void'(val_q.pop_front());
      end
      checks++;
      if (cfg !== exp_cfg) begin
        errors++;
        $display("FAIL %s cfg actual %h expected %h at cycle %0d", tag, cfg, exp_cfg, pc);
      end
      checks++;
      if (sda_pull !== exp_pull) begin
        errors++;
        $display("FAIL %s pull actual %b expected %b at cycle %0d", tag, sda_pull, exp_pull, pc);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check_cfg(input string req, input logic [31:0] expv);
    checks++;
    if (cfg !== expv) begin
      errors++;
      $display("FAIL %s final cfg actual %h expected %h", req, cfg, expv);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(H);
    scl_m = 1'b1; tick(H);
    sda_m = 1'b0; m_active = 1; m_idx = 0; tick(H);
    scl_m = 1'b0; tick(H);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(H);
    scl_m = 1'b1; tick(H);
    sda_m = 1'b1; m_active = 0; tick(H);
  endtask

  task automatic send_byte(input logic [7:0] b);
    bit ack;
    int p;
    ack = 0;
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(H);
      scl_m = 1'b1; tick(H);
      scl_m = 1'b0; p = pc;
      if (i == 0) begin
        if (m_active) begin
          if (m_idx == 0) ack = (b == MYADDR);
          else if (m_idx < 10) ack = 1;
        end
        if (ack) begin
          sched(p + 3, 0, 32'd1);
          if (m_idx >= 6 && m_idx <= 9) begin
            nxt_cfg[(m_idx-6)*8 +: 8] = b & WMASK[(m_idx-6)*8 +: 8];
            sched(p + 4, 1, nxt_cfg);
          end
        end else begin
          m_active = 0;
        end
      end
      tick(H);
    end
    sda_m = 1'b1; tick(H);
    scl_m = 1'b1; tick(H);
    scl_m = 1'b0; p = pc;
    if (ack) begin
      sched(p + 3, 0, 32'd0);
      m_idx++;
      if (m_idx == 10) m_active = 0;
    end
    tick(H);
  endtask

  task automatic send_frame(input logic [7:0] a, input logic [7:0] c0, input logic [7:0] c1,
                            input logic [31:0] regs);
    bus_start();
    send_byte(a); send_byte(c0); send_byte(c1);
    send_byte(8'h11); send_byte(8'h22); send_byte(8'h33);
    for (int k = 0; k < 4; k++) send_byte(regs[k*8 +: 8]);
    bus_stop();
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired, actual running expected finished");
    finish_run();
  end

  initial begin
    tick(5);
    rst = 1'b0;
    tick(2);
    // R6: reset state.
    tag = "R6";
    check_cfg("R6", DEFV);
    checks++;
    if (sda_pull !== 1'b0) begin
      errors++;
      $display("FAIL R6 pull actual %b expected 0", sda_pull);
    end

    // R2 R3 R4 R5 R7 R10: full matching frame, values not bit-palindromic.
    tag = "R2 R3 R4 R5 R7 R10";
    send_frame(MYADDR, 8'hD2, 8'h00, 32'h022A00C8);
    tick(10);
    check_cfg("R2 R5", 32'h022A00C8);

    // R1: near-miss addresses.
    tag = "R1";
    send_frame(8'hD3, 8'h00, 8'h07, 32'h13131313);
    send_frame(8'h69, 8'h00, 8'h07, 32'h13131313);
    tick(10);
    check_cfg("R1", 32'h022A00C8);

    // R12: reserved bits masked.
    tag = "R12";
    send_frame(MYADDR, 8'hFF, 8'hFF, 32'hFFFFFFFF);
    tick(10);
    check_cfg("R12", WMASK);

    // R9: stop after two register bytes.
    tag = "R9";
    bus_start();
    send_byte(MYADDR); send_byte(8'h5A); send_byte(8'hA5);
    send_byte(8'h00); send_byte(8'h00); send_byte(8'h00);
    send_byte(8'h09); send_byte(8'h02);
    bus_stop();
    tick(10);
    check_cfg("R9", 32'h137F0209);

    // R8: restart in the middle of a frame.
    tag = "R8";
    bus_start();
    send_byte(MYADDR); send_byte(8'h00); send_byte(8'h0A);
    send_byte(8'hD2); send_byte(8'h01);
    send_frame(MYADDR, 8'h01, 8'h02, 32'h10300388);
    tick(10);
    check_cfg("R8", 32'h10300388);

    // R11: bytes beyond the tenth.
    tag = "R11";
    bus_start();
    send_byte(MYADDR); send_byte(8'h00); send_byte(8'h04);
    send_byte(8'h00); send_byte(8'h00); send_byte(8'h00);
    send_byte(8'h40); send_byte(8'h01); send_byte(8'h00); send_byte(8'h10);
    send_byte(8'hFF); send_byte(8'hFF);
    bus_stop();
    tick(10);
    check_cfg("R11", 32'h10000140);

    // R3 R4: unusual command/count/skip values, then defaults restored.
    tag = "R3 R4";
    send_frame(MYADDR, 8'hFF, 8'hD2, DEFV);
    tick(10);
    check_cfg("R3 R4", DEFV);

    finish_run();
  end

endmodule